// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Arbiter

This block chooses which of N interrupt sources a simple CPU core should service next. Each source presents a pending line, an enable bit and a one-bit priority that selects the low or the high level. The arbiter captures the enabled requests in a register every clock cycle and decodes a winner from that captured copy. When the core reports an instruction boundary, interrupts are globally enabled, the core is not stalled and nothing blocks the winner, the arbiter raises a call request carrying the winner's vector index. It holds that request until the core accepts the call.

The arbiter keeps one in-service flag per level. Accepting a call sets the flag of the granted level. A return from the handler clears the high flag if it is set and the low flag otherwise. While a low handler runs, only a high request can cut in. While a high handler runs, nothing can. After every return, the next instruction must complete before a new call is raised.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, `callReq` is 0 and both in-service levels are clear, so the first call may be of either level.
- R2: `callReq` rises only in the cycle after one in which `instrDone` = 1, `globalEn` = 1 and `stall` = 0. Once raised, it stays at 1 with `callVec` unchanged until a cycle with `callAck` = 1, and it is 0 in the following cycle.
- R3: A source takes part in the decision only if its pending and enable bits were both 1 in the cycle before the boundary cycle. A request that first appears in the boundary cycle itself is not taken at that boundary. A source whose enable bit is 0 is never chosen.
- R4: A `prioIn` bit of 1 means high priority and 0 means low. When requests of both levels are eligible, a high one is chosen.
- R5: Among eligible requests of the same level, the lowest source index is chosen, and `callVec` carries that index in binary.
- R6: While a low-level handler is in service and no high-level handler is, only high-level requests can be issued. Low-level requests wait.
- R7: While a high-level handler is in service, no call is issued.
- R8: `retPulse` clears the high in-service level if it is set, and otherwise clears the low level. A second return is needed to release low-level requests after a nested high handler.
- R9: No call is issued in a cycle with `retPulse` = 1, nor at the first `instrDone` boundary after it. The second boundary after a return may issue a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pendIn | input | N | Pending flag of each source |
| enableIn | input | N | Per-source enable |
| prioIn | input | N | Per-source priority, 1 = high level |
| globalEn | input | 1 | Global interrupt enable |
| instrDone | input | 1 | Pulse marking an instruction boundary |
| stall | input | 1 | Core stalled; no call is issued |
| retPulse | input | 1 | Pulse marking a return from a handler |
| callAck | input | 1 | Core has accepted the pending call |
| callReq | output | 1 | Call request to the core |
| callVec | output | log2(N) | Index of the source being called |

## Verification
The bench goes after the corner cases below. Each wrong design fails in a visible way.

- **Nested handlers:** a high handler runs on top of a low one and returns. A design that clears both levels on one return, or clears the wrong one, lets a low request through a cycle early.
- **Boundary after a return:** a design that counts the return's own boundary as the completing instruction issues a call one boundary too soon.
- **Late-arriving request:** a request that first shows up in the boundary cycle exposes a design that decodes the live inputs instead of the captured copy.
- **Ordering and masking:** mixed-level requests and masked sources catch an inverted priority bit, a wrong same-level order, or a source that ignores its enable bit.
- **Random traffic:** long random stimulus is compared cycle by cycle against a reference model written from the requirements.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int LVL_LO = 0;
  localparam int LVL_HI = 1;

  // control-to-datapath strobes
  typedef struct packed {
    logic issue;   // latch winner as the outgoing call
    logic accept;  // core took the call: mark granted level in service
    logic retire;  // handler returned: drop the top in-service level
  } ctlStrobe_t;
endpackage

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
  parameter int N = 8,
  parameter int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  reqs,
  output logic          hit,
  output logic [VW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqs[i]) begin
        hit = 1'b1;
        idx = VW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irqArbPkg::*;
#(
  parameter int N = 8,
  parameter int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pendIn,
  input  logic [N-1:0]  enableIn,
  input  logic [N-1:0]  prioIn,
  input  ctlStrobe_t    strb,
  output logic          winValid,
  output logic [VW-1:0] callVec,
  output logic          inSvcHi,
  output logic          inSvcLo,
  output logic          grantHi
);
  logic [1:0][N-1:0]  lvlReq;
  logic [1:0]         lvlHit;
  logic [1:0][VW-1:0] lvlIdx;
  logic               hiOk, loOk, winHi;
  logic [VW-1:0]      winIdx;

  // one-cycle detection: capture enabled requests split by level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvlReq <= '0;
    end else begin
      lvlReq[LVL_HI] <= pendIn & enableIn & prioIn;
      lvlReq[LVL_LO] <= pendIn & enableIn & ~prioIn;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irq_arb_pick #(.N(N), .VW(VW)) u_pick (
      .reqs(lvlReq[g]),
      .hit (lvlHit[g]),
      .idx (lvlIdx[g])
    );
  end

  // nesting rules: high handler blocks all, low handler blocks low
  assign hiOk     = !inSvcHi;
  assign loOk     = !inSvcHi && !inSvcLo;
  assign winHi    = lvlHit[LVL_HI] && hiOk;
  assign winValid = winHi || (lvlHit[LVL_LO] && loOk);
  assign winIdx   = winHi ? lvlIdx[LVL_HI] : lvlIdx[LVL_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      callVec <= '0;
      grantHi <= 1'b0;
      inSvcHi <= 1'b0;
      inSvcLo <= 1'b0;
    end else begin
      if (strb.issue) begin
        callVec <= winIdx;
        grantHi <= winHi;
      end
      if (strb.retire) begin
        if (inSvcHi) inSvcHi <= 1'b0;
        else         inSvcLo <= 1'b0;
      end
      if (strb.accept) begin
        if (grantHi) inSvcHi <= 1'b1;
        else         inSvcLo <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_arb_ctl.sv
module irq_arb_ctl
  import irqArbPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       globalEn,
  input  logic       instrDone,
  input  logic       stall,
  input  logic       retPulse,
  input  logic       callAck,
  input  logic       winValid,
  output ctlStrobe_t strb,
  output logic       callReq
);
  logic holdQ;  // set by a return, cleared by the next completed instruction

  assign strb.issue  = !callReq && instrDone && globalEn && !stall &&
                       !holdQ && !retPulse && winValid;
  assign strb.accept = callReq && callAck;
  assign strb.retire = retPulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdQ   <= 1'b0;
      callReq <= 1'b0;
    end else begin
      if (retPulse)       holdQ <= 1'b1;
      else if (instrDone) holdQ <= 1'b0;

      if (strb.issue)       callReq <= 1'b1;
      else if (strb.accept) callReq <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import irqArbPkg::*;
#(
  parameter int N = 8,
  parameter int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pendIn,
  input  logic [N-1:0]  enableIn,
  input  logic [N-1:0]  prioIn,
  input  logic          globalEn,
  input  logic          instrDone,
  input  logic          stall,
  input  logic          retPulse,
  input  logic          callAck,
  output logic          callReq,
  output logic [VW-1:0] callVec
);
  ctlStrobe_t strb;
  logic       winValid, inSvcHi, inSvcLo, grantHi;

  irq_arb_dp #(.N(N), .VW(VW)) u_dp (
    .clk(clk), .rst_n(rst_n), .pendIn(pendIn), .enableIn(enableIn),
    .prioIn(prioIn), .strb(strb), .winValid(winValid), .callVec(callVec),
    .inSvcHi(inSvcHi), .inSvcLo(inSvcLo), .grantHi(grantHi)
  );

  irq_arb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .instrDone(instrDone),
    .stall(stall), .retPulse(retPulse), .callAck(callAck),
    .winValid(winValid), .strb(strb), .callReq(callReq)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          globalEn,
  input logic          instrDone,
  input logic          stall,
  input logic          retPulse,
  input logic          callAck,
  input logic          callReq,
  input logic [VW-1:0] callVec,
  input logic          inSvcHi,
  input logic          inSvcLo,
  input logic          grantHi
);
  assert_hold_until_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    callReq && !callAck |=> callReq && $stable(callVec));

  assert_issue_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(callReq) |-> $past(instrDone && globalEn && !stall));

  assert_low_only_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(callReq) && $past(inSvcLo) |-> grantHi);

  assert_high_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(callReq) |-> !$past(inSvcHi));

  assert_return_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retPulse |=> !$rose(callReq));
endmodule

bind prio_irq_arbiter irq_arb_checker #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .instrDone(instrDone),
  .stall(stall), .retPulse(retPulse), .callAck(callAck), .callReq(callReq),
  .callVec(callVec), .inSvcHi(inSvcHi), .inSvcLo(inSvcLo), .grantHi(grantHi)
);

// File: tb/test_prio_irq_arbiter.sv
`timescale 1ns/1ps
module test_prio_irq_arbiter;
  localparam int N = 8;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pendIn = '0, enableIn = '1, prioIn = '0;
  logic globalEn = 1'b1, instrDone = 1'b0, stall = 1'b0, retPulse = 1'b0, callAck = 1'b0;
  logic callReq;
  logic [VW-1:0] callVec;

  int vecs = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  string phase = "R1";

  always #5 clk = ~clk;

  prio_irq_arbiter #(.N(N)) i_prio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .pendIn(pendIn), .enableIn(enableIn),
    .prioIn(prioIn), .globalEn(globalEn), .instrDone(instrDone),
    .stall(stall), .retPulse(retPulse), .callAck(callAck),
    .callReq(callReq), .callVec(callVec)
  );

  // ---- reference model built from the requirements ----
  logic [N-1:0] mHiQ, mLoQ;
  bit mInHi, mInLo, mHold, mReq, mGrantHi;
  int mVec;

  function automatic int lowestSet(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mHiQ = '0; mLoQ = '0; mInHi = 0; mInLo = 0; mHold = 0;
      mReq = 0; mVec = 0; mGrantHi = 0;
    end else begin
      bit hiOk, loOk, issue, nHi, nLo, nHold;
      int hiW, loW;
      hiOk = !mInHi;
      loOk = !mInHi && !mInLo;
      hiW = lowestSet(mHiQ);
      loW = lowestSet(mLoQ);
      issue = !mReq && instrDone && globalEn && !stall && !mHold && !retPulse &&
              ((hiW >= 0 && hiOk) || (loW >= 0 && loOk));
      nHi = mInHi; nLo = mInLo;
      if (retPulse) begin if (mInHi) nHi = 0; else nLo = 0; end
      if (mReq && callAck) begin if (mGrantHi) nHi = 1; else nLo = 1; end
      nHold = retPulse ? 1'b1 : (instrDone ? 1'b0 : mHold);
      if (issue) begin
        mGrantHi = (hiW >= 0 && hiOk);
        mVec = mGrantHi ? hiW : loW;
        mReq = 1;
      end else if (mReq && callAck) begin
        mReq = 0;
      end
      mInHi = nHi; mInLo = nLo; mHold = nHold;
      mHiQ = pendIn & enableIn & prioIn;
      mLoQ = pendIn & enableIn & ~prioIn;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, sampled away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(callReq == mReq, {phase, " model callReq"}, int'(callReq), int'(mReq));
      if (mReq) check(int'(callVec) == mVec, {phase, " model callVec"}, int'(callVec), mVec);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic boundary();
    instrDone = 1'b1; step(); instrDone = 1'b0;
  endtask

  task automatic doAck();
    callAck = 1'b1; step(); callAck = 1'b0;
  endtask

  task automatic doRet();
    retPulse = 1'b1; step(); retPulse = 1'b0;
  endtask

  task automatic expectCall(bit req, int vec, string tag);
    check(callReq == req, {tag, " callReq"}, int'(callReq), int'(req));
    if (req) check(int'(callVec) == vec, {tag, " callVec"}, int'(callVec), vec);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    bad++;
    $display("FAIL watchdog: actual %0d expected 0 cycles over limit", cyc);
    summary();
  end

  initial begin
    int seedSink;
    seedSink = $urandom(32'd2024);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expectCall(0, 0, "R1 after reset");

    // R3: request appearing in the boundary cycle is not taken there
    phase = "R3";
    pendIn = 8'h40; boundary(); pendIn = '0;
    expectCall(0, 0, "R3 late request");
    step(); step();

    // R5: two low sources, lowest index wins; R2 hold until ack
    phase = "R5";
    pendIn = 8'h28; step(); boundary();
    expectCall(1, 3, "R5 lowest low index");
    step(); step();
    expectCall(1, 3, "R2 held without ack");
    doAck();
    expectCall(0, 0, "R2 dropped after ack");

    // R6: low in service blocks low, admits high
    phase = "R6";
    pendIn = 8'h22; step(); boundary();
    expectCall(0, 0, "R6 low blocked by low");
    prioIn = 8'h40; pendIn = 8'h62; step(); boundary();
    expectCall(1, 6, "R6 high preempts low");
    doAck();

    // R7: high in service blocks everything
    phase = "R7";
    prioIn = 8'h44; pendIn = 8'h66; step(); boundary();
    expectCall(0, 0, "R7 high not preempted");

    // R9 + R8: return, blocked boundary, then high allowed over low handler
    phase = "R9";
    retPulse = 1'b1; instrDone = 1'b1; step(); retPulse = 1'b0; instrDone = 1'b0;
    expectCall(0, 0, "R9 no call on return cycle");
    boundary();
    expectCall(0, 0, "R9 first boundary after return");
    boundary();
    expectCall(1, 2, "R8 high allowed, low still in service");
    doAck();
    phase = "R8";
    pendIn = 8'h22; step();
    doRet(); boundary(); boundary();
    expectCall(0, 0, "R8 low still blocked after one return");
    doRet(); boundary(); boundary();
    expectCall(1, 1, "R8 low released after second return");
    doAck(); doRet(); boundary();

    // R2 gating by global enable and stall; R3 masking
    phase = "R2";
    globalEn = 1'b0; boundary(); globalEn = 1'b1;
    expectCall(0, 0, "R2 global enable off");
    stall = 1'b1; boundary(); stall = 1'b0;
    expectCall(0, 0, "R2 stalled");
    phase = "R3";
    enableIn = 8'hFD; step(); boundary();
    expectCall(1, 5, "R3 masked source skipped");
    doAck(); doRet(); boundary();
    enableIn = '1;

    // R4: high source beats lower-index low source
    phase = "R4";
    pendIn = 8'h81; prioIn = 8'h80; step(); boundary();
    expectCall(1, 7, "R4 high over low");
    doAck(); doRet(); boundary();

    // random traffic against the model (R4/R5/R6/R7/R8/R9)
    phase = "RND R2/R4/R5/R6/R7/R8/R9";
    rst_n = 1'b0; pendIn = '0; step(); step(); rst_n = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      pendIn    = N'($urandom);
      enableIn  = N'($urandom) | N'($urandom);
      prioIn    = N'($urandom);
      globalEn  = ($urandom % 10) != 0;
      instrDone = ($urandom % 5) < 2;
      stall     = ($urandom % 10) == 0;
      callAck   = mReq && (($urandom % 2) == 0);
      retPulse  = (mInHi || mInLo) && (($urandom % 8) == 0);
      step();
    end
    retPulse = 1'b0; callAck = 1'b0; instrDone = 1'b0;
    step();
    summary();
  end
endmodule